// File: doc/BRIEF.md
# AFSK Tone Modulator with Zero-Bit Insertion

This block turns a stream of bytes into an audio-rate frequency-shift-keyed waveform. A direct digital synthesis core walks a 512-step phase circle and looks up a quarter-wave sine table, so it produces an 8-bit unsigned sample on every pulse of an external sample strobe. A pulse rate of 9600 per second gives 1200 bit/s. Each byte is sent least significant bit first with NRZI coding: a 0 flips between the 1200 Hz mark tone and the 2200 Hz space tone, and a 1 keeps the current tone.

After five consecutive ones the sequencer inserts an extra tone flip, which is HDLC zero-bit insertion, so the frame delimiter pattern cannot appear inside data. The delimiter values 0x7E and 0x7F, when sent bare, go out with insertion disabled. A 0x1B prefix byte makes the byte that follows go out as ordinary data, even when it has one of those values. Transmission starts by itself when a byte is offered while the block is idle. It ends at a byte boundary when no byte is waiting.

Top module: `afsk_tone_tx`

## Requirements
- R1: Quarter-table entry i (0..127) equals floor(128 + 127.5·sin(2π·i/512)). For a phase p (0..511), let h = p mod 256. The table index is h when h < 128 and 255 − h otherwise. The sample is the table value when p < 256 and 255 minus it when p ≥ 256.
- R2: On each strobe that produces a sample, the phase advances by 64 on the mark tone or 117 on the space tone, modulo 512. `sample_out` then takes the sample for the new phase. Without a strobe, `sample_out` keeps its value.
- R3: Every transmitted bit, including an inserted one, lasts 8 produced samples. The tone is chosen at the first of those samples. Data bits go out LSB first. A data 1 keeps the tone and adds one to a run counter. A data 0 flips the tone and clears the counter.
- R4: While insertion is enabled and the run counter has reached 5, the next bit slot holds an inserted bit instead. That bit flips the tone and clears the counter, and the pending data bit waits for the slot after it.
- R5: A byte of 0x7E or 0x7F that is not preceded by an escape is sent with insertion disabled. When a byte starts right after a byte sent with insertion disabled, the run counter is cleared first.
- R6: A 0x1B byte is an escape. It is absorbed from the input on any clock cycle at a byte boundary. The next byte, whatever its value (0x1B included), is then sent with insertion enabled. If the boundary strobe finds no byte after an escape, or if the escape itself arrives on the boundary strobe cycle, the escape is dropped and transmission stops.
- R7: When the block is idle and `in_valid` is high, `busy` rises on the next clock edge. The block then starts at phase 0 on the mark tone with the run counter cleared, and it is at a byte boundary. When a boundary strobe has no byte to take, `busy` falls and `sample_out` holds its last value. `busy` never falls in the middle of a byte.
- R8: `in_ready` is high only while busy at a byte boundary. On the strobe cycle it is high for any data. On other cycles it is high only for an escape byte while no escape is held. A data byte is therefore taken only on a strobe.
- R9: While `rst` is high (synchronous), the block goes idle. `busy` is 0, `in_ready` is 0 and `sample_out` is 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_tick | input | 1 | One-cycle output sample strobe |
| in_data | input | 8 | Byte offered for transmission |
| in_valid | input | 1 | `in_data` holds a byte |
| in_ready | output | 1 | Byte taken this cycle when `in_valid` is high |
| sample_out | output | 8 | Unsigned sine sample, midscale 128 |
| busy | output | 1 | Transmission in progress |

## Verification
`in_ready` is combinational, so the bench checks it in the same cycle, one time unit after it changes the inputs away from the clock edge. `sample_out` and `busy` come from registers. Their new values are due one clock after the edge where the strobe or the start condition was present, and the bench compares them at the next falling edge. A bench model updates its state at each clock from the inputs it has just driven. This gives a cycle-exact expected value for every cycle of the directed byte patterns (NRZI, runs of ones, bare delimiters, escapes, a trailing escape) and of a long random run with random strobe timing and random input gaps.

// File: rtl/afsk_pkg.sv
package afsk_pkg;

    localparam int SAMPLE_W        = 8;
    localparam int PHASE_W         = 9;
    localparam int BITS_PER_BYTE   = 8;
    localparam int SAMPLES_PER_BIT = 8;
    localparam int STUFF_LIMIT     = 5;
    localparam int MARK_STEP       = 64;
    localparam int SPACE_STEP      = 117;

    localparam logic [7:0] ESC_CODE   = 8'h1B;
    localparam logic [7:0] FLAG_CODE  = 8'h7E;
    localparam logic [7:0] ABORT_CODE = 8'h7F;

    typedef enum logic {
        TONE_MARK  = 1'b0,
        TONE_SPACE = 1'b1
    } tone_e;

    // control state of the byte sequencer
    typedef struct packed {
        logic  busy;
        logic  esc;
        logic  stuff_en;
        tone_e tone;
    } seq_ctl_t;

    function automatic tone_e tone_flip(tone_e t);
        return (t == TONE_MARK) ? TONE_SPACE : TONE_MARK;
    endfunction

    // delimiter values that go out without zero-bit insertion when bare
    function automatic logic is_bare_delim(logic [7:0] b);
        return (b == FLAG_CODE) || (b == ABORT_CODE);
    endfunction

    // floor(mid + amp*sin(pi/2 * idx/qlen)), sine by a Taylor series
    function automatic int quarter_entry(int idx, int qlen, int width);
        real x;
        real term;
        real acc;
        real mid;
        real amp;
        x    = (3.14159265358979323846 / 2.0) * real'(idx) / real'(qlen);
        term = x;
        acc  = x;
        for (int k = 1; k < 12; k++) begin
            term = -term * x * x / real'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        mid = real'(1 << (width - 1));
        amp = real'((1 << width) - 1) / 2.0;
        return $rtoi(mid + amp * acc);
    endfunction

endpackage

// File: rtl/afsk_sine_rom.sv
module afsk_sine_rom #(
    parameter int PHASE_W  = afsk_pkg::PHASE_W,
    parameter int SAMPLE_W = afsk_pkg::SAMPLE_W
) (
    input  logic [PHASE_W-1:0]  phase,
    output logic [SAMPLE_W-1:0] sample
);
    localparam int QBITS = PHASE_W - 2;
    localparam int QLEN  = 1 << QBITS;

    logic [SAMPLE_W-1:0] qtab [QLEN];
    logic [QBITS-1:0]    q_idx;
    logic [SAMPLE_W-1:0] q_val;

    for (genvar gi = 0; gi < QLEN; gi++) begin : g_quarter
        localparam int ENTRY = afsk_pkg::quarter_entry(gi, QLEN, SAMPLE_W);
        assign qtab[gi] = SAMPLE_W'(ENTRY);
    end

    always_comb begin
        // second half of each half-period runs the quarter backwards
        q_idx  = phase[PHASE_W-2] ? ~phase[QBITS-1:0] : phase[QBITS-1:0];
        q_val  = qtab[q_idx];
        // negative half-period is the complement around midscale
        sample = phase[PHASE_W-1] ? ~q_val : q_val;
    end
endmodule

// File: rtl/afsk_phase_acc.sv
module afsk_phase_acc #(
    parameter int PHASE_W    = afsk_pkg::PHASE_W,
    parameter int MARK_STEP  = afsk_pkg::MARK_STEP,
    parameter int SPACE_STEP = afsk_pkg::SPACE_STEP
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               step,
    input  logic               space,
    output logic [PHASE_W-1:0] phase_next
);
    localparam logic [PHASE_W-1:0] MARK_INC  = PHASE_W'(MARK_STEP);
    localparam logic [PHASE_W-1:0] SPACE_INC = PHASE_W'(SPACE_STEP);

    logic [PHASE_W-1:0] phase_q;

    // modulo 2^PHASE_W wrap comes from the register width
    assign phase_next = phase_q + (space ? SPACE_INC : MARK_INC);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            phase_q <= '0;
        end else if (step) begin
            phase_q <= phase_next;
        end
    end

    assert_step_size_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !start) |=> ((PHASE_W'(phase_q - $past(phase_q)) == MARK_INC) ||
                              (PHASE_W'(phase_q - $past(phase_q)) == SPACE_INC)));

    assert_start_phase_R7: assert property (@(posedge clk) disable iff (rst)
        start |=> (phase_q == '0));

    assert_idle_phase_R2: assert property (@(posedge clk) disable iff (rst)
        (!step && !start) |=> $stable(phase_q));
endmodule

// File: rtl/afsk_bit_seq.sv
module afsk_bit_seq
    import afsk_pkg::*;
#(
    parameter int BITS_PER_BYTE   = afsk_pkg::BITS_PER_BYTE,
    parameter int SAMPLES_PER_BIT = afsk_pkg::SAMPLES_PER_BIT,
    parameter int STUFF_LIMIT     = afsk_pkg::STUFF_LIMIT
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_tick,
    input  logic [BITS_PER_BYTE-1:0] in_data,
    input  logic                     in_valid,
    output logic                     in_ready,
    output logic                     busy,
    output logic                     start,
    output logic                     step,
    output logic                     space_next
);
    localparam int BITPOS_W  = $clog2(BITS_PER_BYTE + 1);
    localparam int BIT_IDX_W = $clog2(BITS_PER_BYTE);
    localparam int SCNT_W    = $clog2(SAMPLES_PER_BIT);
    localparam int ONES_W    = $clog2(BITS_PER_BYTE + STUFF_LIMIT + 1);

    localparam logic [BITPOS_W-1:0] LAST_POS = BITPOS_W'(BITS_PER_BYTE);
    localparam logic [SCNT_W-1:0]   SCNT_TOP = SCNT_W'(SAMPLES_PER_BIT - 1);
    localparam logic [ONES_W-1:0]   RUN_CAP  = ONES_W'(STUFF_LIMIT);
    localparam logic [BITS_PER_BYTE-1:0] ESC_V = BITS_PER_BYTE'(ESC_CODE);

    seq_ctl_t                 ctl_q;
    logic [ONES_W-1:0]        ones_q;
    logic [BITPOS_W-1:0]      bpos_q;
    logic [SCNT_W-1:0]        scnt_q;
    logic [BITS_PER_BYTE-1:0] cur_q;

    logic                     at_bound;
    logic                     esc_in;
    logic                     take;
    logic                     stop;
    logic                     new_bit;
    logic [BITS_PER_BYTE-1:0] cur_e;
    logic                     stuff_e;
    logic [ONES_W-1:0]        ones_e;
    logic [BITPOS_W-1:0]      bpos_e;
    logic                     insert;
    logic                     dbit;
    tone_e                    tone_d;

    always_comb begin
        at_bound = ctl_q.busy && (scnt_q == '0) && (bpos_q == LAST_POS);
        esc_in   = (in_data == ESC_V);
        in_ready = at_bound && (sample_tick || (!ctl_q.esc && esc_in));
        take     = at_bound && sample_tick && in_valid && (ctl_q.esc || !esc_in);
        stop     = at_bound && sample_tick && !take;
        start    = !ctl_q.busy && in_valid;
        step     = ctl_q.busy && sample_tick && !stop;
        new_bit  = step && (scnt_q == '0);

        // effective byte context for the bit being chosen
        cur_e   = take ? in_data : cur_q;
        stuff_e = take ? (ctl_q.esc || !is_bare_delim(8'(in_data))) : ctl_q.stuff_en;
        ones_e  = (take && !ctl_q.stuff_en) ? '0 : ones_q;
        bpos_e  = take ? '0 : bpos_q;

        insert  = stuff_e && (ones_e >= RUN_CAP);
        dbit    = cur_e[bpos_e[BIT_IDX_W-1:0]];
        tone_d  = (new_bit && (insert || !dbit)) ? tone_flip(ctl_q.tone) : ctl_q.tone;

        busy       = ctl_q.busy;
        space_next = (tone_d == TONE_SPACE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q  <= '{busy: 1'b0, esc: 1'b0, stuff_en: 1'b0, tone: TONE_MARK};
            ones_q <= '0;
            bpos_q <= LAST_POS;
            scnt_q <= '0;
            cur_q  <= '0;
        end else if (start) begin
            ctl_q  <= '{busy: 1'b1, esc: 1'b0, stuff_en: 1'b0, tone: TONE_MARK};
            ones_q <= '0;
            bpos_q <= LAST_POS;
            scnt_q <= '0;
        end else if (ctl_q.busy) begin
            if (stop) begin
                ctl_q.busy <= 1'b0;
                ctl_q.esc  <= 1'b0;
            end else if (in_ready && in_valid && !sample_tick) begin
                ctl_q.esc <= 1'b1;
            end else if (new_bit) begin
                cur_q          <= cur_e;
                ctl_q.stuff_en <= stuff_e;
                ctl_q.esc      <= 1'b0;
                ctl_q.tone     <= tone_d;
                ones_q         <= (insert || !dbit) ? '0 : ones_e + ONES_W'(1);
                bpos_q         <= insert ? bpos_e : bpos_e + BITPOS_W'(1);
                scnt_q         <= SCNT_TOP;
            end else if (step) begin
                scnt_q <= scnt_q - SCNT_W'(1);
            end
        end
    end

    assert_run_cap_R4: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.busy && ctl_q.stuff_en) |-> (ones_q <= RUN_CAP));

    assert_ready_gate_R8: assert property (@(posedge clk) disable iff (rst)
        (in_ready && !sample_tick) |-> esc_in);

    assert_idle_ready_R7: assert property (@(posedge clk) disable iff (rst)
        !ctl_q.busy |-> !in_ready);

    assert_no_midbyte_stop_R7: assert property (@(posedge clk) disable iff (rst)
        (ctl_q.busy && !at_bound) |=> ctl_q.busy);

    assert_esc_consumed_R6: assert property (@(posedge clk) disable iff (rst)
        take |=> !ctl_q.esc);

    assert_bit_pos_R3: assert property (@(posedge clk) disable iff (rst)
        bpos_q <= LAST_POS);
endmodule

// File: rtl/afsk_tone_tx.sv
module afsk_tone_tx
    import afsk_pkg::*;
#(
    parameter int SAMPLE_W        = afsk_pkg::SAMPLE_W,
    parameter int PHASE_W         = afsk_pkg::PHASE_W,
    parameter int BITS_PER_BYTE   = afsk_pkg::BITS_PER_BYTE,
    parameter int SAMPLES_PER_BIT = afsk_pkg::SAMPLES_PER_BIT,
    parameter int STUFF_LIMIT     = afsk_pkg::STUFF_LIMIT,
    parameter int MARK_STEP       = afsk_pkg::MARK_STEP,
    parameter int SPACE_STEP      = afsk_pkg::SPACE_STEP
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     sample_tick,
    input  logic [BITS_PER_BYTE-1:0] in_data,
    input  logic                     in_valid,
    output logic                     in_ready,
    output logic [SAMPLE_W-1:0]      sample_out,
    output logic                     busy
);
    localparam logic [SAMPLE_W-1:0] MIDSCALE = SAMPLE_W'(1 << (SAMPLE_W - 1));

    logic               start;
    logic               step;
    logic               space_next;
    logic [PHASE_W-1:0] phase_next;
    logic [SAMPLE_W-1:0] rom_val;

    afsk_bit_seq #(
        .BITS_PER_BYTE  (BITS_PER_BYTE),
        .SAMPLES_PER_BIT(SAMPLES_PER_BIT),
        .STUFF_LIMIT    (STUFF_LIMIT)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .sample_tick(sample_tick),
        .in_data    (in_data),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .busy       (busy),
        .start      (start),
        .step       (step),
        .space_next (space_next)
    );

    afsk_phase_acc #(
        .PHASE_W   (PHASE_W),
        .MARK_STEP (MARK_STEP),
        .SPACE_STEP(SPACE_STEP)
    ) u_acc (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .step      (step),
        .space     (space_next),
        .phase_next(phase_next)
    );

    afsk_sine_rom #(
        .PHASE_W (PHASE_W),
        .SAMPLE_W(SAMPLE_W)
    ) u_rom (
        .phase (phase_next),
        .sample(rom_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sample_out <= MIDSCALE;
        end else if (step) begin
            sample_out <= rom_val;
        end
    end

    assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (rst)
        !sample_tick |=> $stable(sample_out));

    assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !busy |=> $stable(sample_out));
endmodule

// File: tb/afsk_tone_tx_tb.sv
module afsk_tone_tx_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       tick;
    logic [7:0] dat;
    logic       vld;
    logic       in_ready;
    logic [7:0] sample_out;
    logic       busy;

    always #2 clk = ~clk;

    afsk_tone_tx u_dut (
        .clk        (clk),
        .rst        (rst),
        .sample_tick(tick),
        .in_data    (dat),
        .in_valid   (vld),
        .in_ready   (in_ready),
        .sample_out (sample_out),
        .busy       (busy)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0] src_q[$];

    // expected-value state
    bit         m_busy, m_esc, m_stuff, m_tone, m_escd;
    int         m_ones, m_bpos, m_scnt, m_phase, m_out;
    logic [7:0] m_cur;
    string      m_tag;

    localparam real PI = 3.14159265358979323846;

    function automatic int sine_ref(int ph);
        int h = ph % 256;
        int q = (h >= 128) ? 255 - h : h;
        int v = $rtoi(128.0 + 127.5 * $sin(2.0 * PI * real'(q) / 512.0));
        return (ph >= 256) ? 255 - v : v;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_busy = 0; m_esc = 0; m_stuff = 0; m_tone = 0; m_escd = 0;
        m_ones = 0; m_bpos = 8; m_scnt = 0; m_phase = 0; m_out = 128;
        m_cur = '0; m_tag = "R2";
    endtask

    // advance expected state across one clock edge; returns expected ready
    function automatic bit model_step(bit t, bit v, logic [7:0] d);
        bit at_b   = m_busy && (m_scnt == 0) && (m_bpos == 8);
        bit esc_in = (d == 8'h1B);
        bit rdy    = at_b && (t || (!m_esc && esc_in));
        bit take;
        if (!m_busy) begin
            if (v) begin
                m_busy = 1; m_esc = 0; m_stuff = 0; m_tone = 0;
                m_ones = 0; m_bpos = 8; m_scnt = 0; m_phase = 0;
            end
        end else if (at_b && !t) begin
            if (v && esc_in && !m_esc) m_esc = 1;
        end else if (t) begin
            take = at_b && v && (m_esc || !esc_in);
            if (at_b && !take) begin
                m_busy = 0; m_esc = 0;
            end else begin
                if (m_scnt == 0) begin
                    if (take) begin
                        m_escd = m_esc;
                        m_cur  = d;
                        if (!m_stuff) m_ones = 0;
                        m_stuff = m_esc || !((d == 8'h7E) || (d == 8'h7F));
                        m_esc  = 0;
                        m_bpos = 0;
                    end
                    if (m_stuff && m_ones >= 5) begin
                        m_tone = !m_tone; m_ones = 0; m_tag = "R4";
                    end else begin
                        if (m_cur[m_bpos[2:0]]) m_ones++;
                        else begin m_tone = !m_tone; m_ones = 0; end
                        m_bpos++;
                        m_tag = !m_stuff ? "R5" : (m_escd ? "R6" : "R3");
                    end
                    m_scnt = 7;
                end else begin
                    m_scnt--;
                end
                m_phase = (m_phase + (m_tone ? 117 : 64)) % 512;
                m_out   = sine_ref(m_phase);
            end
        end
        return rdy;
    endfunction

    // one clock: called at a falling edge, returns at the next falling edge
    task automatic cycle(input bit t, input bit allow);
        bit e_rdy;
        tick = t;
        vld  = allow && (src_q.size() > 0);
        dat  = vld ? src_q[0] : 8'h00;
        #1;
        e_rdy = model_step(t, vld, dat);
        chk("R8 in_ready", in_ready, e_rdy);
        @(posedge clk);
        @(negedge clk);
        if (vld && e_rdy) void'(src_q.pop_front());
        chk({"R1 sample ", m_tag}, sample_out, m_out);
        chk("R7 busy", busy, m_busy);
    endtask

    task automatic run_bytes(input logic [7:0] b0, input logic [7:0] b1,
                             input logic [7:0] b2, input int n);
        int guard = 0;
        if (n > 0) src_q.push_back(b0);
        if (n > 1) src_q.push_back(b1);
        if (n > 2) src_q.push_back(b2);
        cycle(1'b0, 1'b1);
        while ((m_busy || src_q.size() > 0) && guard < 2000) begin
            cycle((guard % 4) == 3, 1'b1);
            guard++;
        end
        for (int k = 0; k < 3; k++) cycle(1'b1, 1'b0);
        chk("R7 idle after bytes", busy, 0);
        src_q.delete();
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R7 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        rst = 1; tick = 0; vld = 0; dat = 8'h00;
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R9 reset busy", busy, 0);
        chk("R9 reset sample", sample_out, 128);
        chk("R9 reset ready", in_ready, 0);
        rst = 0;

        // NRZI on alternating and zero bytes
        run_bytes(8'h00, 8'h55, 8'hA3, 3);
        // long runs of ones force insertion
        run_bytes(8'hFF, 8'hFF, 8'h3F, 3);
        // bare delimiters, then a stuffed byte after them
        run_bytes(8'h7E, 8'h7F, 8'hFF, 3);
        // escaped delimiter and escaped escape
        run_bytes(8'h1B, 8'h7E, 8'hFF, 3);
        run_bytes(8'h1B, 8'h1B, 8'h7F, 3);
        // trailing escape with nothing after it
        run_bytes(8'h55, 8'h1B, 8'h00, 2);
        chk("R6 trailing escape stops", busy, 0);

        // random traffic with random strobe timing and source gaps
        for (int i = 0; i < 6000; i++) begin
            if (src_q.size() < 4) begin
                int r = $urandom_range(0, 99);
                logic [7:0] b;
                if (r < 15)      b = 8'h1B;
                else if (r < 25) b = 8'h7E;
                else if (r < 35) b = 8'h7F;
                else if (r < 55) b = 8'hFF;
                else             b = 8'($urandom());
                src_q.push_back(b);
            end
            cycle($urandom_range(0, 3) == 0, $urandom_range(0, 5) != 0);
        end

        // mid-run reset
        src_q.push_back(8'hC5);
        for (int i = 0; i < 20; i++) cycle((i % 4) == 1, 1'b1);
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        src_q.delete();
        vld = 0;
        #1;
        chk("R9 reset mid-run busy", busy, 0);
        chk("R9 reset mid-run sample", sample_out, 128);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule